// File: doc/BRIEF.md
# UART Register and FIFO Front End

This block is the software-visible side of a serial port. A simple 32-bit read/write bus reaches five registers: a control word, a baud divisor word, a FIFO threshold word, a status word and a data port. A write to the data port queues one character for the transmitter. A read of the data port takes the oldest received character, together with its error tags, from the receive queue. Each direction has its own 16-entry queue.

The bit shifter and the baud tick generator are separate blocks. They connect through handshakes. The transmitter sees a valid/take pair on the head of the transmit queue. The receiver presents each finished character with a one-cycle push strobe. The control word drives the enable outputs, and it also carries two command bits that empty the queues at once. A sticky overrun flag records a character lost against a full receive queue.

The bus is word-addressed by byte offset and has no wait states. Read data is combinational from the address in the cycle where select is high and write is low. A data-port pop takes effect at the clock edge that ends that cycle.

Top module: `uart_regfile`

## Requirements
- R1: After synchronous reset, the control, baud and threshold registers read 0, both queues are empty, the status word reads 0x20 and tx_valid is low.
- R2: The control register (offset 0x00) stores every written bit except bits 6 and 7. The baud register (0x04) stores all 32 bits. The threshold register (0x08) stores bits 15:8 only, and its other bits read 0.
- R3: Writing control bit 6 empties the receive queue and writing control bit 7 empties the transmit queue, both at that same write edge. Both bits always read back 0.
- R4: A write to the data port (0x14) queues bits 7:0 for transmission. When the transmit queue already holds 16 characters, the write is dropped.
- R5: tx_valid is high only while control bit 22 is set and the transmit queue is not empty. tx_char is the oldest queued character, and a tx_take pulse removes it, so characters leave in write order.
- R6: An rx_valid pulse pushes {rx_brk, rx_par_err, rx_frame_err, rx_char} only while control bit 21 is set. With bit 21 clear, the pulse is ignored.
- R7: A data-port read of a non-empty receive queue returns the character in bits 7:0, the frame error in bit 8, the parity error in bit 9 and the break flag in bit 10. The read removes that entry.
- R8: A data-port read of an empty receive queue returns 0 and removes nothing.
- R9: In the status word (0x10), bit 5 is high while the transmit queue is empty and bit 11 is high while the receive queue is not empty. Both bits follow the queue state at all times.
- R10: Status bit 7 sets when an enabled rx_valid arrives while the receive queue is full. That character is discarded, and the bit stays set through later reads and pushes.
- R11: The overrun bit clears on a receive-queue reset or on a write of 0 to the status register. A non-zero write to the status register has no effect on it.
- R12: The outputs rx_en, tx_en and brg_en follow control bits 21, 22 and 23. The outputs baud_word, rx_thresh and tx_thresh follow the baud register and threshold bits 11:8 and 15:12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid during a read cycle |
| rx_char | input | 8 | Received character |
| rx_frame_err | input | 1 | Frame error tag of rx_char |
| rx_par_err | input | 1 | Parity error tag of rx_char |
| rx_brk | input | 1 | Break tag of rx_char |
| rx_valid | input | 1 | One-cycle push of a received character |
| tx_char | output | 8 | Head of the transmit queue |
| tx_valid | output | 1 | Character available to the shifter |
| tx_take | input | 1 | Shifter accepts tx_char |
| rx_en | output | 1 | Receiver enable |
| tx_en | output | 1 | Transmitter enable |
| brg_en | output | 1 | Baud generator enable |
| baud_word | output | 32 | Baud divisor word |
| rx_thresh | output | 4 | Receive threshold |
| tx_thresh | output | 4 | Transmit threshold |

## Verification
The assertions assume that tx_take comes only while tx_valid is high. They also assume that bus_sel and rx_valid are single-cycle strobes with settled data. The bench meets this by driving every input at the falling edge. It holds each strobe for exactly one clock, and it raises tx_take only after it has seen tx_valid high. Reads sample bus_rdata within the read cycle, before the edge that pops.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;

    localparam int DATA_W = 32;
    localparam int CHAR_W = 8;

    // register byte offsets (software-visible, fixed)
    localparam logic [7:0] OFF_CTL  = 8'h00;
    localparam logic [7:0] OFF_BAUD = 8'h04;
    localparam logic [7:0] OFF_THR  = 8'h08;
    localparam logic [7:0] OFF_STAT = 8'h10;
    localparam logic [7:0] OFF_DATA = 8'h14;

    // control bit positions
    localparam int CTL_RXFLUSH = 6;
    localparam int CTL_TXFLUSH = 7;
    localparam int CTL_RXEN    = 21;
    localparam int CTL_TXEN    = 22;
    localparam int CTL_BRGEN   = 23;

    // status bit positions
    localparam int ST_TXEMPTY = 5;
    localparam int ST_OVR     = 7;
    localparam int ST_RXAVAIL = 11;

    typedef struct packed {
        logic              brk;
        logic              par_err;
        logic              frm_err;
        logic [CHAR_W-1:0] ch;
    } rx_entry_t;

    localparam int RX_ENTRY_W = $bits(rx_entry_t);

    typedef struct packed {
        logic sel_ctl;
        logic sel_baud;
        logic sel_thr;
        logic sel_stat;
        logic sel_data;
    } reg_hit_t;

    function automatic logic [DATA_W-1:0] pack_status(input logic tx_empty,
                                                      input logic ovr,
                                                      input logic rx_avail);
        logic [DATA_W-1:0] w;
        w = '0;
        w[ST_TXEMPTY] = tx_empty;
        w[ST_OVR]     = ovr;
        w[ST_RXAVAIL] = rx_avail;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] ctl_mask();
        logic [DATA_W-1:0] m;
        m = '1;
        m[CTL_RXFLUSH] = 1'b0;
        m[CTL_TXFLUSH] = 1'b0;
        return m;
    endfunction

endpackage

// File: rtl/uart_queue.sv
module uart_queue #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full,
    output logic [CW-1:0]    count
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));                                            // R4
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        flush |=> empty);                                                // R3
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (full && !pop && !flush) |=> full);                              // R4

endmodule

// File: rtl/uart_status.sv
module uart_status
    import uart_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_push_req,
    input  logic              rx_full,
    input  logic              rx_flush,
    input  logic              stat_wr,
    input  logic [DATA_W-1:0] stat_wdata,
    input  logic              tx_empty,
    input  logic              rx_empty,
    output logic [DATA_W-1:0] status_word
);

    logic ovr_q;
    logic ovr_clr, ovr_set;

    assign ovr_clr = rx_flush || (stat_wr && (stat_wdata == '0));
    assign ovr_set = rx_push_req && rx_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            ovr_q <= 1'b0;
        end else if (ovr_clr) begin
            ovr_q <= 1'b0;
        end else if (ovr_set) begin
            ovr_q <= 1'b1;
        end
    end

    assign status_word = pack_status(tx_empty, ovr_q, !rx_empty);

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ovr_q && !ovr_clr) |=> ovr_q);                                  // R10
    AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (!ovr_q && !(rx_push_req && rx_full)) |=> !ovr_q);               // R10
    AST_OVR_CLEARS: assert property (@(posedge clk) disable iff (rst)
        ovr_clr |=> !ovr_q);                                             // R11

endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
    import uart_regs_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [7:0]        rx_char,
    input  logic              rx_frame_err,
    input  logic              rx_par_err,
    input  logic              rx_brk,
    input  logic              rx_valid,
    output logic [7:0]        tx_char,
    output logic              tx_valid,
    input  logic              tx_take,
    output logic              rx_en,
    output logic              tx_en,
    output logic              brg_en,
    output logic [31:0]       baud_word,
    output logic [3:0]        rx_thresh,
    output logic [3:0]        tx_thresh
);

    localparam int CW = $clog2(DEPTH + 1);

    reg_hit_t          hit;
    logic              wr_acc, rd_acc;
    logic [DATA_W-1:0] ctl_q, baud_q;
    logic [7:0]        thr_q;
    logic              rx_flush, tx_flush;
    logic              rx_push_req, rx_pop;
    rx_entry_t         rx_in, rx_head;
    logic              rx_empty, rx_full, tx_empty, tx_full;
    logic [CW-1:0]     rx_count, tx_count;
    logic [DATA_W-1:0] status_word;

    assign hit.sel_ctl  = (bus_addr == OFF_CTL[ADDR_W-1:0]);
    assign hit.sel_baud = (bus_addr == OFF_BAUD[ADDR_W-1:0]);
    assign hit.sel_thr  = (bus_addr == OFF_THR[ADDR_W-1:0]);
    assign hit.sel_stat = (bus_addr == OFF_STAT[ADDR_W-1:0]);
    assign hit.sel_data = (bus_addr == OFF_DATA[ADDR_W-1:0]);

    assign wr_acc = bus_sel && bus_wr;
    assign rd_acc = bus_sel && !bus_wr;

    // self-clearing flush commands act at the write edge, never stored
    assign rx_flush = wr_acc && hit.sel_ctl && bus_wdata[CTL_RXFLUSH];
    assign tx_flush = wr_acc && hit.sel_ctl && bus_wdata[CTL_TXFLUSH];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            baud_q <= '0;
            thr_q  <= '0;
        end else if (wr_acc) begin
            if (hit.sel_ctl)  ctl_q  <= bus_wdata & ctl_mask();
            if (hit.sel_baud) baud_q <= bus_wdata;
            if (hit.sel_thr)  thr_q  <= bus_wdata[15:8];
        end
    end

    assign rx_en     = ctl_q[CTL_RXEN];
    assign tx_en     = ctl_q[CTL_TXEN];
    assign brg_en    = ctl_q[CTL_BRGEN];
    assign baud_word = baud_q;
    assign rx_thresh = thr_q[3:0];
    assign tx_thresh = thr_q[7:4];

    // receive path
    assign rx_in.brk     = rx_brk;
    assign rx_in.par_err = rx_par_err;
    assign rx_in.frm_err = rx_frame_err;
    assign rx_in.ch      = rx_char;
    assign rx_push_req   = rx_valid && rx_en;
    assign rx_pop        = rd_acc && hit.sel_data;

    uart_queue #(.WIDTH(RX_ENTRY_W), .DEPTH(DEPTH)) i_rxq (
        .clk      (clk),
        .rst      (rst),
        .flush    (rx_flush),
        .push     (rx_push_req),
        .push_data(rx_in),
        .pop      (rx_pop),
        .head     (rx_head),
        .empty    (rx_empty),
        .full     (rx_full),
        .count    (rx_count)
    );

    // transmit path
    uart_queue #(.WIDTH(CHAR_W), .DEPTH(DEPTH)) i_txq (
        .clk      (clk),
        .rst      (rst),
        .flush    (tx_flush),
        .push     (wr_acc && hit.sel_data),
        .push_data(bus_wdata[7:0]),
        .pop      (tx_take && tx_valid),
        .head     (tx_char),
        .empty    (tx_empty),
        .full     (tx_full),
        .count    (tx_count)
    );

    assign tx_valid = tx_en && !tx_empty;

    uart_status i_stat (
        .clk        (clk),
        .rst        (rst),
        .rx_push_req(rx_push_req),
        .rx_full    (rx_full),
        .rx_flush   (rx_flush),
        .stat_wr    (wr_acc && hit.sel_stat),
        .stat_wdata (bus_wdata),
        .tx_empty   (tx_empty),
        .rx_empty   (rx_empty),
        .status_word(status_word)
    );

    always_comb begin
        bus_rdata = '0;
        if (rd_acc) begin
            unique case (1'b1)
                hit.sel_ctl:  bus_rdata = ctl_q;
                hit.sel_baud: bus_rdata = baud_q;
                hit.sel_thr:  bus_rdata = {16'h0, thr_q, 8'h0};
                hit.sel_stat: bus_rdata = status_word;
                hit.sel_data: bus_rdata = rx_empty ? '0 : {21'h0, rx_head};
                default:      bus_rdata = '0;
            endcase
        end
    end

    AST_TX_GATED: assert property (@(posedge clk) disable iff (rst)
        !tx_en |-> !tx_valid);                                           // R5
    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rx_pop && rx_empty) |-> (bus_rdata == '0));                     // R8
    AST_EMPTY_READ_NO_POP: assert property (@(posedge clk) disable iff (rst)
        (rx_pop && rx_empty && !rx_push_req) |=> rx_empty);              // R8
    AST_POP_ONE: assert property (@(posedge clk) disable iff (rst)
        (rx_pop && !rx_empty && !rx_push_req && !rx_flush)
            |=> (rx_count == $past(rx_count) - 1'b1));                   // R7
    AST_TX_IGNORED_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
        (tx_full && !tx_flush && !(tx_take && tx_valid)) |=> tx_full);   // R4
    AST_CTL_FLUSH_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_acc && hit.sel_ctl) |-> (bus_rdata[7:6] == 2'b00));          // R3
    AST_RX_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (!rx_en && !rx_pop && !rx_flush) |=> (rx_count == $past(rx_count))); // R6

endmodule

// File: tb/test_uart_regfile.sv
module test_uart_regfile;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_sel, bus_wr;
    logic [4:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic [7:0]  rx_char;
    logic        rx_frame_err, rx_par_err, rx_brk, rx_valid;
    logic [7:0]  tx_char;
    logic        tx_valid, tx_take;
    logic        rx_en, tx_en, brg_en;
    logic [31:0] baud_word;
    logic [3:0]  rx_thresh, tx_thresh;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    uart_regfile i_uart_regfile (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_char(rx_char), .rx_frame_err(rx_frame_err), .rx_par_err(rx_par_err),
        .rx_brk(rx_brk), .rx_valid(rx_valid), .tx_char(tx_char),
        .tx_valid(tx_valid), .tx_take(tx_take), .rx_en(rx_en), .tx_en(tx_en),
        .brg_en(brg_en), .baud_word(baud_word), .rx_thresh(rx_thresh),
        .tx_thresh(tx_thresh)
    );

    typedef struct packed {
        logic [4:0]  addr;
        logic [31:0] wdata;
        logic [31:0] expect_rd;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VEC [NVEC] = '{
        '{5'h00, 32'hFFFF_FFFF, 32'hFFFF_FF3F},
        '{5'h00, 32'h00E0_00C5, 32'h00E0_0005},
        '{5'h04, 32'h1234_5678, 32'h1234_5678},
        '{5'h08, 32'hFFFF_FFFF, 32'h0000_FF00},
        '{5'h08, 32'h0000_A300, 32'h0000_A300},
        '{5'h00, 32'h0000_0000, 32'h0000_0000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic rx_send(input logic [10:0] e);
        @(negedge clk);
        {rx_brk, rx_par_err, rx_frame_err, rx_char} = e;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic tx_pull(input string req, input logic [7:0] exp);
        @(negedge clk);
        check(req, {31'h0, tx_valid}, 32'h1);
        check(req, {24'h0, tx_char}, {24'h0, exp});
        tx_take = 1'b1;
        @(negedge clk);
        tx_take = 1'b0;
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        rst = 1'b1; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        rx_char = '0; rx_frame_err = 1'b0; rx_par_err = 1'b0; rx_brk = 1'b0;
        rx_valid = 1'b0; tx_take = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        bus_read(5'h00, rd); check("R1 ctl", rd, 32'h0);
        bus_read(5'h04, rd); check("R1 baud", rd, 32'h0);
        bus_read(5'h08, rd); check("R1 thr", rd, 32'h0);
        bus_read(5'h10, rd); check("R1 status", rd, 32'h20);
        check("R1 tx_valid", {31'h0, tx_valid}, 32'h0);

        // R2 R3 register table
        for (int i = 0; i < NVEC; i++) begin
            bus_write(VEC[i].addr, VEC[i].wdata);
            bus_read(VEC[i].addr, rd);
            check("R2 table", rd, VEC[i].expect_rd);
        end
        check("R12 baud_word", baud_word, 32'h1234_5678);
        check("R12 thresholds", {24'h0, tx_thresh, rx_thresh}, 32'hA3);

        // R12 enable outputs
        bus_write(5'h00, 32'h00A0_0000);
        check("R12 enables", {29'h0, brg_en, tx_en, rx_en}, 32'h5);

        // R5 transmitter disabled holds characters
        bus_write(5'h14, 32'hFFFF_FF11);
        bus_write(5'h14, 32'h0000_0022);
        @(negedge clk);
        check("R5 gated", {31'h0, tx_valid}, 32'h0);
        bus_read(5'h10, rd); check("R9 tx not empty", rd, 32'h0);
        bus_write(5'h00, 32'h00E0_0000);
        check("R12 enables all", {29'h0, brg_en, tx_en, rx_en}, 32'h7);
        tx_pull("R5 first", 8'h11);
        tx_pull("R5 second", 8'h22);
        @(negedge clk);
        check("R5 drained", {31'h0, tx_valid}, 32'h0);

        // R4 17 writes, 17th dropped
        bus_write(5'h00, 32'h00A0_0000);
        for (int i = 0; i < 17; i++) bus_write(5'h14, 32'h40 + i);
        bus_write(5'h00, 32'h00E0_0000);
        for (int i = 0; i < 16; i++) tx_pull("R4 order", 8'(8'h40 + i));
        @(negedge clk);
        check("R4 17th dropped", {31'h0, tx_valid}, 32'h0);
        bus_read(5'h10, rd); check("R9 tx empty", rd, 32'h20);

        // R6 receiver disabled
        bus_write(5'h00, 32'h00C0_0000);
        rx_send(11'h055);
        bus_read(5'h10, rd); check("R6 ignored", rd, 32'h20);
        bus_read(5'h14, rd); check("R6 nothing queued", rd, 32'h0);

        // R7 tags, R8 empty read
        bus_write(5'h00, 32'h00E0_0000);
        rx_send({3'b001, 8'h41});
        rx_send({3'b110, 8'h7E});
        bus_read(5'h10, rd); check("R9 rx avail", rd, 32'h820);
        bus_read(5'h14, rd); check("R7 frame tag", rd, 32'h141);
        bus_read(5'h14, rd); check("R7 break parity tags", rd, 32'h67E);
        bus_read(5'h14, rd); check("R8 empty read", rd, 32'h0);
        bus_read(5'h10, rd); check("R8 no pop", rd, 32'h20);

        // R10 overrun
        for (int i = 0; i < 17; i++) rx_send(11'(8'h80 + i));
        bus_read(5'h10, rd); check("R10 overrun set", rd, 32'h8A0);
        for (int i = 0; i < 16; i++) begin
            bus_read(5'h14, rd); check("R10 kept data", rd, 32'h80 + i);
        end
        bus_read(5'h14, rd); check("R10 17th lost", rd, 32'h0);
        bus_read(5'h10, rd); check("R10 sticky", rd, 32'hA0);

        // R11 clear rules
        bus_write(5'h10, 32'h0000_0080);
        bus_read(5'h10, rd); check("R11 nonzero write", rd, 32'hA0);
        bus_write(5'h10, 32'h0);
        bus_read(5'h10, rd); check("R11 zero write", rd, 32'h20);
        for (int i = 0; i < 17; i++) rx_send(11'h033);
        bus_write(5'h00, 32'h00E0_0040);
        bus_read(5'h10, rd); check("R3 R11 rx flush", rd, 32'h20);
        bus_read(5'h00, rd); check("R3 bit6 reads 0", rd, 32'h00E0_0000);

        // R3 transmit flush
        bus_write(5'h00, 32'h00A0_0000);
        bus_write(5'h14, 32'h5A);
        bus_write(5'h14, 32'hA5);
        bus_write(5'h00, 32'h00E0_0080);
        bus_read(5'h10, rd); check("R3 tx flush", rd, 32'h20);
        check("R3 tx_valid after flush", {31'h0, tx_valid}, 32'h0);
        bus_read(5'h00, rd); check("R3 bit7 reads 0", rd, 32'h00E0_0000);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule